// File: doc/BRIEF.md
# Display RAM Address Window Sequencer

This block produces the column and row address used to access a graphic display RAM. Software first sets a rectangular window by giving a column range and a row range. After that it issues a stream of data accesses. After each access the pointer moves on by itself, so a whole rectangle of pixels can be filled or read back with no further address commands.

The pointer walks in one of two orders. In horizontal order it moves along a row, then steps down to the next row. In vertical order it moves down a column, then steps right to the next column. In both orders the window repeats when it has been fully traversed.

On the way to and from the RAM, the data byte can have its two nibbles exchanged. The column address can also be mirrored, for panels whose segments are wired right to left. The RAM array, panel scanning and command decoding sit outside this block.

Top module: `disp_addr_seq`

## Requirements
- R1: After reset, the column pointer is 0 and the row pointer is 0. The column window is 0 to 63, the row window is 0 to 127, and every mode bit is clear (horizontal order, no swap, no mirror).
- R2: A column window write stores the new start and end values and loads the column pointer with the start value. The row pointer is left unchanged.
- R3: A row window write stores the new start and end values and loads the row pointer with the start value. The column pointer is left unchanged.
- R4: With mode bit 2 clear (horizontal order), each access increments the column pointer. When the column pointer is at or beyond the column end, it returns to the column start and the row pointer advances.
- R5: With mode bit 2 set (vertical order), each access increments the row pointer. When the row pointer is at or beyond the row end, it returns to the row start and the column pointer advances.
- R6: The secondary pointer (the row in horizontal order, the column in vertical order) also returns from its end to its start. The window therefore repeats without limit, including across the top of the full address range (63 to 0, 127 to 0).
- R7: If a start value is greater than its end value, each advance of that pointer reloads the start value and counts as a wrap.
- R8: With mode bit 1 set, bits 7..4 and 3..0 are exchanged on both the write path (wdata_i to ram_wdata_o) and the read path (ram_rdata_i to rdata_o). With mode bit 1 clear, both paths pass the byte through unchanged.
- R9: With mode bit 0 set, phys_col_o is the bitwise complement of col_o, which is 63 minus col_o. With mode bit 0 clear, phys_col_o equals col_o.
- R10: An access in the same cycle as any window or mode write is ignored. In a cycle with no access and no write, both pointers hold their values.
- R11: A mode write does not move either pointer. The new order applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_win_we_i | input | 1 | Column window write strobe |
| col_start_i | input | 6 | Column window start |
| col_end_i | input | 6 | Column window end |
| row_win_we_i | input | 1 | Row window write strobe |
| row_start_i | input | 7 | Row window start |
| row_end_i | input | 7 | Row window end |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode: bit 2 vertical order, bit 1 nibble swap, bit 0 column mirror |
| access_i | input | 1 | One RAM data access this cycle |
| wdata_i | input | 8 | Write data from the host |
| ram_wdata_o | output | 8 | Write data toward the RAM |
| ram_rdata_i | input | 8 | Read data from the RAM |
| rdata_o | output | 8 | Read data toward the host |
| col_o | output | 6 | Logical column pointer |
| phys_col_o | output | 6 | Physical column address after mirroring |
| row_o | output | 7 | Row pointer |

## Verification
The containment assertion assumes that each pointer only takes values reached by a window load or an advance. It therefore applies only while the window is well formed, that is, while the start is not greater than the end. The single-step assertions assume that an access never coincides with a configuration write, except where that cycle is itself the subject of the check.

The stimulus follows these rules: it changes the window or the mode only in cycles of their own, apart from one deliberate collision used to show that the access is dropped. Reversed windows are entered only through the normal window strobes, so the pointer always starts from a loaded start value.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  localparam int unsigned MODE_W = 3;

  typedef struct packed {
    logic vert;        // bit 2
    logic nib_swap;    // bit 1
    logic col_mirror;  // bit 0
  } mode_t;
endpackage

// File: rtl/addr_axis.sv
module addr_axis #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic         step_i,
  output logic [W-1:0] ptr_o,
  output logic [W-1:0] start_o,
  output logic [W-1:0] end_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] ptr_q, start_q, end_q;

  // at or past the end (covers reversed windows)
  assign wrap_o = (ptr_q >= end_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      start_q <= '0;
      end_q   <= FULL;
    end else if (load_i) begin
      ptr_q   <= start_i;
      start_q <= start_i;
      end_q   <= end_i;
    end else if (step_i) begin
      ptr_q <= wrap_o ? start_q : ptr_q + W'(1);
    end
  end

  assign ptr_o   = ptr_q;
  assign start_o = start_q;
  assign end_o   = end_q;
endmodule

// File: rtl/nibble_remap.sv
module nibble_remap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              swap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HALF = DATA_W / 2;

  assign data_o = swap_i ? {data_i[HALF-1:0], data_i[DATA_W-1:HALF]} : data_i;
endmodule

// File: rtl/disp_addr_seq.sv
module disp_addr_seq #(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              col_win_we_i,
  input  logic [COL_W-1:0]  col_start_i,
  input  logic [COL_W-1:0]  col_end_i,
  input  logic              row_win_we_i,
  input  logic [ROW_W-1:0]  row_start_i,
  input  logic [ROW_W-1:0]  row_end_i,
  input  logic              mode_we_i,
  input  logic [2:0]        mode_i,
  input  logic              access_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [COL_W-1:0]  col_o,
  output logic [COL_W-1:0]  phys_col_o,
  output logic [ROW_W-1:0]  row_o
);
  import disp_addr_pkg::*;

  mode_t            mode_q;
  logic             cfg_busy, adv, col_step, row_step, col_wrap, row_wrap;
  logic [COL_W-1:0] col_start_q, col_end_q;
  logic [ROW_W-1:0] row_start_q, row_end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_t'(mode_i);
  end

  assign cfg_busy = col_win_we_i | row_win_we_i | mode_we_i;
  assign adv      = access_i & ~cfg_busy;
  // primary axis steps every access, secondary on primary wrap
  assign col_step = adv & (~mode_q.vert | row_wrap);
  assign row_step = adv & ( mode_q.vert | col_wrap);

  addr_axis #(.W(COL_W)) u_col (
    .clk_i, .rst_ni,
    .load_i  (col_win_we_i),
    .start_i (col_start_i),
    .end_i   (col_end_i),
    .step_i  (col_step),
    .ptr_o   (col_o),
    .start_o (col_start_q),
    .end_o   (col_end_q),
    .wrap_o  (col_wrap)
  );

  addr_axis #(.W(ROW_W)) u_row (
    .clk_i, .rst_ni,
    .load_i  (row_win_we_i),
    .start_i (row_start_i),
    .end_i   (row_end_i),
    .step_i  (row_step),
    .ptr_o   (row_o),
    .start_o (row_start_q),
    .end_o   (row_end_q),
    .wrap_o  (row_wrap)
  );

  assign phys_col_o = mode_q.col_mirror ? ~col_o : col_o;

  nibble_remap #(.DATA_W(DATA_W)) u_wr_remap (
    .swap_i (mode_q.nib_swap), .data_i (wdata_i), .data_o (ram_wdata_o)
  );

  nibble_remap #(.DATA_W(DATA_W)) u_rd_remap (
    .swap_i (mode_q.nib_swap), .data_i (ram_rdata_i), .data_o (rdata_o)
  );
endmodule

// File: rtl/disp_addr_seq_chk.sv
module disp_addr_seq_chk #(
  parameter int unsigned COL_W  = 6,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned DATA_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     col_win_we_i,
  input logic [COL_W-1:0]         col_start_i,
  input logic                     row_win_we_i,
  input logic [ROW_W-1:0]         row_start_i,
  input logic                     mode_we_i,
  input logic                     access_i,
  input logic [DATA_W-1:0]        wdata_i,
  input logic [DATA_W-1:0]        ram_wdata_o,
  input logic [COL_W-1:0]         col_o,
  input logic [COL_W-1:0]         phys_col_o,
  input logic [ROW_W-1:0]         row_o,
  input disp_addr_pkg::mode_t     mode_q,
  input logic [COL_W-1:0]         col_start_q,
  input logic [COL_W-1:0]         col_end_q,
  input logic [ROW_W-1:0]         row_start_q,
  input logic [ROW_W-1:0]         row_end_q
);
  localparam int unsigned HALF = DATA_W / 2;
  logic quiet;
  assign quiet = !col_win_we_i && !row_win_we_i && !mode_we_i;

  a_r2_col_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_win_we_i && !row_win_we_i) |=> (col_o == $past(col_start_i)) && $stable(row_o));

  a_r3_row_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_win_we_i && !col_win_we_i) |=> (row_o == $past(row_start_i)) && $stable(col_o));

  a_r4_horz_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && quiet && !mode_q.vert && col_o < col_end_q)
      |=> (col_o == $past(col_o) + COL_W'(1)) && $stable(row_o));

  a_r5_vert_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && quiet && mode_q.vert && row_o < row_end_q)
      |=> (row_o == $past(row_o) + ROW_W'(1)) && $stable(col_o));

  a_r6_col_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_start_q <= col_end_q) |-> (col_o >= col_start_q && col_o <= col_end_q));

  a_r6_row_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_start_q <= row_end_q) |-> (row_o >= row_start_q && row_o <= row_end_q));

  a_r8_nibble_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.nib_swap |-> ram_wdata_o == {wdata_i[HALF-1:0], wdata_i[DATA_W-1:HALF]});

  a_r9_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.col_mirror |-> (phys_col_o + col_o == {COL_W{1'b1}}));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_i && quiet) |=> $stable(col_o) && $stable(row_o));

  a_r11_mode_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !col_win_we_i && !row_win_we_i) |=> $stable(col_o) && $stable(row_o));
endmodule

bind disp_addr_seq disp_addr_seq_chk #(
  .COL_W(COL_W), .ROW_W(ROW_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/disp_addr_seq_test.sv
module disp_addr_seq_test;
  localparam int COL_W = 6, ROW_W = 7, DATA_W = 8;
  localparam int COL_MAX = (1 << COL_W) - 1;
  localparam int ROW_MAX = (1 << ROW_W) - 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic col_win_we_i = 0, row_win_we_i = 0, mode_we_i = 0, access_i = 0;
  logic [COL_W-1:0] col_start_i = '0, col_end_i = '0;
  logic [ROW_W-1:0] row_start_i = '0, row_end_i = '0;
  logic [2:0] mode_i = '0;
  logic [DATA_W-1:0] wdata_i = '0, ram_rdata_i = '0, ram_wdata_o, rdata_o;
  logic [COL_W-1:0] col_o, phys_col_o;
  logic [ROW_W-1:0] row_o;

  int n_chk = 0, n_fail = 0;
  int e_col, e_row, cs, ce, rs, re, e_mode;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  disp_addr_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) uut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nxt(int p, int s, int e);
    return (p >= e) ? s : p + 1;
  endfunction

  task automatic check_ptrs(string req);
    check({req, " col"}, int'(col_o), e_col);
    check({req, " row"}, int'(row_o), e_row);
    check({req, " phys"}, int'(phys_col_o),
          e_mode[0] ? COL_MAX - e_col : e_col);
  endtask

  task automatic set_col(int s, int e);
    col_start_i = COL_W'(s); col_end_i = COL_W'(e); col_win_we_i = 1;
    @(negedge clk_i); col_win_we_i = 0;
    cs = s; ce = e; e_col = s;
    check_ptrs("R2");
  endtask

  task automatic set_row(int s, int e);
    row_start_i = ROW_W'(s); row_end_i = ROW_W'(e); row_win_we_i = 1;
    @(negedge clk_i); row_win_we_i = 0;
    rs = s; re = e; e_row = s;
    check_ptrs("R3");
  endtask

  task automatic set_mode(int m);
    mode_i = 3'(m); mode_we_i = 1;
    @(negedge clk_i); mode_we_i = 0;
    e_mode = m;
    check_ptrs("R11");
  endtask

  task automatic acc(string req);
    int nc, nr;
    access_i = 1;
    @(negedge clk_i); access_i = 0;
    nc = e_col; nr = e_row;
    if (e_mode[2]) begin
      nr = nxt(e_row, rs, re);
      if (e_row >= re) nc = nxt(e_col, cs, ce);
    end else begin
      nc = nxt(e_col, cs, ce);
      if (e_col >= ce) nr = nxt(e_row, rs, re);
    end
    e_col = nc; e_row = nr;
    check_ptrs(req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cs = 0; ce = COL_MAX; rs = 0; re = ROW_MAX; e_col = 0; e_row = 0; e_mode = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check_ptrs("R1");
    check("R1 mode", int'(ram_wdata_o), int'(wdata_i));

    // full-range horizontal, across the end of a row
    repeat (70) acc("R4");

    // small window, horizontal sweep
    set_col(2, 5);
    set_row(10, 12);
    repeat (40) acc("R4");
    // vertical sweep over the same window
    set_mode(4);
    repeat (40) acc("R5");
    set_mode(5);
    repeat (30) acc("R9");

    // wrap across top of range
    set_mode(0);
    set_col(62, COL_MAX);
    set_row(126, ROW_MAX);
    repeat (12) acc("R6");
    set_mode(4);
    repeat (12) acc("R6");

    // reversed windows
    set_mode(0);
    set_col(9, 3);
    set_row(20, 40);
    repeat (6) acc("R7");
    check("R7 col stays", int'(col_o), 9);
    set_mode(4);
    set_col(1, 4);
    set_row(50, 45);
    repeat (10) acc("R7");

    // access colliding with configuration writes is dropped
    set_mode(0);
    set_col(5, 20);
    set_row(0, 3);
    acc("R10");
    access_i = 1; mode_i = 3'd0; mode_we_i = 1;
    @(negedge clk_i); access_i = 0; mode_we_i = 0;
    check_ptrs("R10");
    access_i = 1; col_start_i = 6'd8; col_end_i = 6'd12; col_win_we_i = 1;
    @(negedge clk_i); access_i = 0; col_win_we_i = 0;
    cs = 8; ce = 12; e_col = 8;
    check_ptrs("R10");
    repeat (3) @(negedge clk_i);
    check_ptrs("R10 idle");

    // data path, exhaustive, both settings
    for (int m = 0; m < 2; m++) begin
      set_mode(m * 2);
      for (int v = 0; v < 256; v++) begin
        wdata_i = 8'(v); ram_rdata_i = 8'(255 - v);
        #0.5;
        check("R8 wr", int'(ram_wdata_o),
              m ? ((v & 15) << 4) | (v >> 4) : v);
        check("R8 rd", int'(rdata_o),
              m ? (((255 - v) & 15) << 4) | ((255 - v) >> 4) : 255 - v);
      end
      @(negedge clk_i);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule